// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block is the transmit half of an asynchronous serial port. The host loads characters into a single holding register. From there each character moves into a shift register and goes out on a serial line, one bit for every 16 pulses of a bit-rate tick. Single-cycle command pulses control the transmitter:

- switch it on or off
- abort it back to idle
- begin and end a break, a long low period on the line
- tag the next character as an address in multidrop mode

The break logic enforces the line timing by itself. A requested break begins only after every queued character has left the line. A request to end the break takes effect only once the break has lasted one full character frame. The line then stays high for twelve bit periods before any new character may start. Three flags tell the host what it may do next: holding register empty, transmitter fully empty, and break active.

Top module: `uart_brk_tx`

## Requirements
- R1: While rst_n is low and right after it rises, txd is 1, hold_empty is 1, tx_empty is 1, brk_active is 0, and the transmitter is disabled.
- R2: A cmd_tx_on pulse enables the transmitter and a cmd_tx_off pulse disables it. When both arrive in the same cycle, the transmitter ends up disabled.
- R3: A character written while the transmitter is disabled is kept: hold_empty stays 0 and txd stays 1. The character is sent once the transmitter is enabled.
- R4: A frame on txd is laid out in this order:
  - one start bit at 0
  - eight data bits, least significant first
  - one address bit, present only when multidrop is 1
  - one stop bit at 1

  Each bit lasts 16 cycles in which baud_tick is 1. Cycles without a tick do not advance the frame.
- R5: hold_empty falls in the cycle after a write. It rises in the cycle after the character moves into the shift register. tx_empty is 1 only when all of the following hold:
  - the holding register is empty
  - no character is being shifted out
  - no break is pending or active
  - no post-break idle period is running
- R6: A cmd_tx_reset pulse makes txd 1 from the next cycle on. It empties the holding register, drops the character being shifted out, and clears any pending or active break. A held character is never sent. The enable state does not change.
- R7: A cmd_brk_start pulse begins a break only after the holding register and the shift register have both finished. From then on brk_active is 1 and txd is 0.
- R8: A cmd_brk_start pulse while a break is active has no effect. No second break follows the current one.
- R9: After a cmd_brk_stop pulse during a break, txd stays 0 until at least one frame length (16 ticks per frame bit) has passed since the break began. If the stop pulse comes early, the break lasts exactly one frame length. txd is then 1 for 12×16 ticks while tx_empty stays 0, and only after that can a character start.
- R10: A cmd_brk_stop pulse while no break is active has no effect. A later break does not end early because of it.
- R11: A cmd_addr_next pulse marks only the next character written. If multidrop is 1 when that character is written, its address bit is 1. Every later character carries 0. A write made while multidrop is 0 still uses up the mark.
- R12: A cmd_tx_off pulse during a character lets that character finish correctly. No further character starts until the transmitter is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Bit-rate tick, 16 per bit period |
| multidrop | input | 1 | 1 adds an address bit to each frame |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | DATA_W | Character to load |
| cmd_tx_on | input | 1 | Enable pulse |
| cmd_tx_off | input | 1 | Disable pulse, wins over enable |
| cmd_tx_reset | input | 1 | Abort to idle pulse |
| cmd_brk_start | input | 1 | Request a break |
| cmd_brk_stop | input | 1 | Request the end of a break |
| cmd_addr_next | input | 1 | Tag the next written character as an address |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing queued, sending or in break |
| brk_active | output | 1 | Line is held low for a break |

## Verification
The bench targets the timing edges of the break:
- It measures the low and high periods to the cycle when the stop request comes early. A design that counts the minimum break from the stop request, or that shortens the post-break idle, shows the wrong length.
- It sends a stop request before any break exists. A design that latches that request ends the next break at one frame instead of holding the line low.

It also checks the priority and one-shot rules:
- An enable and a disable in the same cycle must not start a held character.
- An address mark must not survive into the second character, nor into a write made with multidrop off.

Finally, a transmitter reset in the middle of a frame must drop both the shifted and the held character, and a break must not begin while a character is still on the line.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BREAK = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_e;

  // Number of bit periods in one frame: start, data, optional address, stop.
  function automatic int unsigned frame_bits(input int unsigned dw, input logic md);
    return dw + 2 + (md ? 1 : 0);
  endfunction

endpackage

// File: rtl/ubt_bitclk.sv
module ubt_bitclk #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic bit_end
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [CW-1:0] sub_q;

  assign bit_end = tick && (sub_q == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub_q <= '0;
    else if (clr)    sub_q <= '0;
    else if (tick)   sub_q <= bit_end ? '0 : sub_q + 1'b1;
  end
endmodule

// File: rtl/ubt_hold.sv
module ubt_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              addr_cmd,
  input  logic              md,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              tag
);
  logic addr_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full        <= 1'b0;
      data        <= '0;
      tag         <= 1'b0;
      addr_pend_q <= 1'b0;
    end else if (flush) begin
      full        <= 1'b0;
      tag         <= 1'b0;
      addr_pend_q <= 1'b0;
    end else begin
      if (wr) begin
        data <= wdata;
        tag  <= addr_pend_q & md;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
      // a write consumes the mark; a new mark pulse re-arms it
      addr_pend_q <= addr_cmd | (addr_pend_q & ~wr);
    end
  end
endmodule

// File: rtl/ubt_engine.sv
module ubt_engine
  import ubt_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned GAP_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tick,
  input  logic              en,
  input  logic              md,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_tag,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              take,
  output logic              txd,
  output logic              idle,
  output logic              brk_on,
  output logic              brk_pend
);
  localparam int unsigned FW   = DATA_W + 3;
  localparam int unsigned MAXB = (FW > GAP_BITS) ? FW : GAP_BITS;
  localparam int unsigned BCW  = $clog2(MAXB + 1);

  tx_state_e        state_q;
  logic [FW-1:0]    shreg_q;
  logic [BCW-1:0]   bit_cnt_q;
  logic [BCW-1:0]   len_q;
  logic             brk_pend_q;
  logic             stop_req_q;

  logic             bit_end;
  logic             load, brk_go, gap_go, shift_done, gap_done, sub_clr;
  logic [BCW-1:0]   brk_len;

  function automatic logic [FW-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                input logic t, input logic m);
    logic [FW-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (m) f[DATA_W+1] = t;
    return f;
  endfunction

  assign brk_len    = BCW'(frame_bits(DATA_W, md));
  assign load       = (state_q == ST_IDLE) && en && hold_full;
  assign brk_go     = (state_q == ST_IDLE) && brk_pend_q && !hold_full;
  assign gap_go     = (state_q == ST_BREAK) && stop_req_q &&
                      ((bit_cnt_q >= brk_len) ||
                       (bit_end && (bit_cnt_q == brk_len - 1'b1)));
  assign shift_done = (state_q == ST_SHIFT) && bit_end && (bit_cnt_q == len_q - 1'b1);
  assign gap_done   = (state_q == ST_GAP) && bit_end && (bit_cnt_q == BCW'(GAP_BITS - 1));
  assign sub_clr    = flush | load | brk_go | gap_go;

  ubt_bitclk #(.OVS(OVS)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sub_clr),
    .tick    (tick),
    .bit_end (bit_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '1;
      bit_cnt_q  <= '0;
      len_q      <= '0;
      brk_pend_q <= 1'b0;
      stop_req_q <= 1'b0;
    end else if (flush) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '1;
      bit_cnt_q  <= '0;
      brk_pend_q <= 1'b0;
      stop_req_q <= 1'b0;
    end else begin
      if (brk_go)                                  brk_pend_q <= 1'b0;
      else if (brk_start && state_q != ST_BREAK)   brk_pend_q <= 1'b1;

      if (gap_go)                                  stop_req_q <= 1'b0;
      else if (brk_stop && state_q == ST_BREAK)    stop_req_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (load) begin
            state_q   <= ST_SHIFT;
            shreg_q   <= build_frame(hold_data, hold_tag, md);
            len_q     <= BCW'(frame_bits(DATA_W, md));
            bit_cnt_q <= '0;
          end else if (brk_go) begin
            state_q   <= ST_BREAK;
            bit_cnt_q <= '0;
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            shreg_q <= {1'b1, shreg_q[FW-1:1]};
            if (shift_done) begin
              state_q   <= ST_IDLE;
              bit_cnt_q <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_BREAK: begin
          if (gap_go) begin
            state_q   <= ST_GAP;
            bit_cnt_q <= '0;
          end else if (bit_end && bit_cnt_q < brk_len) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (bit_end) begin
            if (gap_done) begin
              state_q   <= ST_IDLE;
              bit_cnt_q <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SHIFT: txd = shreg_q[0];
      ST_BREAK: txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign take     = load;
  assign idle     = (state_q == ST_IDLE);
  assign brk_on   = (state_q == ST_BREAK);
  assign brk_pend = brk_pend_q;
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned GAP_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              multidrop,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cmd_tx_on,
  input  logic              cmd_tx_off,
  input  logic              cmd_tx_reset,
  input  logic              cmd_brk_start,
  input  logic              cmd_brk_stop,
  input  logic              cmd_addr_next,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              brk_active
);
  logic              tx_en_q;
  logic              xfer;
  logic              hold_full;
  logic [DATA_W-1:0] held_data;
  logic              held_tag;
  logic              eng_idle;
  logic              brk_pend;

  // disable wins over enable in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_en_q <= 1'b0;
    else if (cmd_tx_off) tx_en_q <= 1'b0;
    else if (cmd_tx_on)  tx_en_q <= 1'b1;
  end

  ubt_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cmd_tx_reset),
    .wr       (hold_wr),
    .wdata    (hold_data),
    .addr_cmd (cmd_addr_next),
    .md       (multidrop),
    .take     (xfer),
    .full     (hold_full),
    .data     (held_data),
    .tag      (held_tag)
  );

  ubt_engine #(.DATA_W(DATA_W), .OVS(OVS), .GAP_BITS(GAP_BITS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cmd_tx_reset),
    .tick      (baud_tick),
    .en        (tx_en_q),
    .md        (multidrop),
    .hold_full (hold_full),
    .hold_data (held_data),
    .hold_tag  (held_tag),
    .brk_start (cmd_brk_start),
    .brk_stop  (cmd_brk_stop),
    .take      (xfer),
    .txd       (txd),
    .idle      (eng_idle),
    .brk_on    (brk_active),
    .brk_pend  (brk_pend)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && eng_idle && !brk_pend;
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker (
  input logic clk,
  input logic rst_n,
  input logic hold_wr,
  input logic cmd_tx_on,
  input logic cmd_tx_off,
  input logic cmd_tx_reset,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty,
  input logic brk_active,
  input logic tx_en,
  input logic xfer
);
  assert_off_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_off |=> !tx_en);

  assert_on_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_on && !cmd_tx_off) |=> tx_en);

  assert_xfer_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hold_wr && !cmd_tx_reset) |=> hold_empty);

  assert_hold_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !xfer && !cmd_tx_reset) |=> !hold_empty);

  assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && hold_empty && !brk_active));

  assert_reset_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_reset |=> (txd && hold_empty && tx_empty && !brk_active));

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> !txd);

  assert_break_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_active) |-> $past(hold_empty));

  assert_gap_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk_active) && !$past(cmd_tx_reset)) |-> (txd && !tx_empty));
endmodule

bind uart_brk_tx ubt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hold_wr      (hold_wr),
  .cmd_tx_on    (cmd_tx_on),
  .cmd_tx_off   (cmd_tx_off),
  .cmd_tx_reset (cmd_tx_reset),
  .txd          (txd),
  .hold_empty   (hold_empty),
  .tx_empty     (tx_empty),
  .brk_active   (brk_active),
  .tx_en        (tx_en_q),
  .xfer         (xfer)
);

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
  localparam bit [5:0] C_ON = 6'd1, C_OFF = 6'd2, C_RST = 6'd4,
                       C_BS = 6'd8, C_BP = 6'd16, C_AD = 6'd32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, baud_tick = 1'b0, multidrop = 1'b0, hold_wr = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic cmd_tx_on = 0, cmd_tx_off = 0, cmd_tx_reset = 0;
  logic cmd_brk_start = 0, cmd_brk_stop = 0, cmd_addr_next = 0;
  logic txd, hold_empty, tx_empty, brk_active;

  int n_tests = 0, n_fail = 0, tick_pct = 100;
  logic [8:0] expq[$];

  uart_brk_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .multidrop(multidrop),
    .hold_wr(hold_wr), .hold_data(hold_data), .cmd_tx_on(cmd_tx_on),
    .cmd_tx_off(cmd_tx_off), .cmd_tx_reset(cmd_tx_reset),
    .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
    .cmd_addr_next(cmd_addr_next), .txd(txd), .hold_empty(hold_empty),
    .tx_empty(tx_empty), .brk_active(brk_active));

  initial begin
    forever begin
      @(posedge clk); #1;
      baud_tick = ($urandom_range(99) < tick_pct);
    end
  end

  function automatic int frame_len(input logic md);
    return md ? 11 : 10;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input bit [5:0] m);
    step();
    {cmd_addr_next, cmd_brk_stop, cmd_brk_start, cmd_tx_reset, cmd_tx_off, cmd_tx_on} = m;
    step();
    {cmd_addr_next, cmd_brk_stop, cmd_brk_start, cmd_tx_reset, cmd_tx_off, cmd_tx_on} = '0;
  endtask

  task automatic write_char(input logic [7:0] d);
    step();
    hold_wr = 1'b1; hold_data = d;
    step();
    hold_wr = 1'b0;
  endtask

  task automatic wait_hold_empty();
    int w = 0;
    @(negedge clk);
    while (!hold_empty && w < 20000) begin @(negedge clk); w++; end
  endtask

  // Bench-side receiver: samples each bit at the middle of its 16 ticks.
  task automatic recv(input logic md, output logic [8:0] v, output logic ok, output logic got);
    int waitc = 0, n = 0, idx = 0, nb;
    logic [10:0] bits = '1;
    nb = frame_len(md);
    got = 1'b0; ok = 1'b0; v = '0;
    @(negedge clk);
    while (txd !== 1'b0 && waitc < 20000) begin @(negedge clk); waitc++; end
    if (txd !== 1'b0) return;
    got = 1'b1;
    while (idx < nb) begin
      if (n == 16 * idx + 8) begin bits[idx] = txd; idx++; end
      if (idx < nb) begin
        if (baud_tick) n++;
        @(negedge clk);
      end
    end
    v  = {md ? bits[9] : 1'b0, bits[8:1]};
    ok = (bits[0] == 1'b0) && (bits[nb-1] == 1'b1);
  endtask

  task automatic recv_check(input string req, input logic md, input logic [8:0] exp);
    logic [8:0] v; logic ok, got;
    recv(md, v, ok, got);
    chk(req, "frame seen", int'(got), 1);
    chk(req, "frame value", int'(v), int'(exp));
    chk(req, "start/stop levels", int'(ok), 1);
  endtask

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  task automatic wait_flag(input bit want_brk);
    int w = 0;
    @(negedge clk);
    while ((want_brk ? !brk_active : !tx_empty) && w < 20000) begin @(negedge clk); w++; end
  endtask

  task automatic random_round(input logic md, input int nch);
    logic pend = 1'b0;
    multidrop = md;
    tick_pct = 30 + $urandom_range(70);
    fork
      begin
        for (int i = 0; i < nch; i++) begin
          logic [7:0] d;
          wait_hold_empty();
          if (md && ($urandom_range(2) == 0)) begin cmd(C_AD); pend = 1'b1; end
          d = 8'($urandom);
          write_char(d);
          expq.push_back({pend & md, d});
          pend = 1'b0;
        end
      end
      begin
        for (int i = 0; i < nch; i++) begin
          logic [8:0] v; logic ok, got;
          recv(md, v, ok, got);
          chk("R4", "random frame seen", int'(got), 1);
          chk(md ? "R11" : "R4", "random frame value", int'(v),
              (expq.size() > 0) ? int'(expq.pop_front()) : -1);
          chk("R4", "random stop level", int'(ok), 1);
        end
      end
    join
    wait_flag(1'b0);
    tick_pct = 100;
  endtask

  initial begin
    int lows, highs;
    logic [8:0] v; logic ok, got;
    void'($urandom(32'd20240611));
    repeat (4) step();
    // R1: reset state
    @(negedge clk);
    chk("R1", "txd in reset", int'(txd), 1);
    chk("R1", "hold_empty in reset", int'(hold_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd after reset", int'(txd), 1);
    chk("R1", "tx_empty after reset", int'(tx_empty), 1);
    chk("R1", "brk_active after reset", int'(brk_active), 0);

    // R3 / R1: write while disabled is held, nothing sent
    write_char(8'hA5);
    count_low(60, lows);
    chk("R3", "line low while disabled", lows, 0);
    chk("R3", "hold_empty while disabled", int'(hold_empty), 0);
    // R2: on and off in the same cycle leaves it disabled
    cmd(C_ON | C_OFF);
    count_low(60, lows);
    chk("R2", "line low after on+off", lows, 0);
    chk("R2", "hold_empty after on+off", int'(hold_empty), 0);
    cmd(C_ON);
    recv_check("R3", 1'b0, 9'h0A5);
    wait_flag(1'b0);

    // R5: flag timing around a write
    write_char(8'h3C);
    @(negedge clk);
    chk("R5", "hold_empty cycle after write", int'(hold_empty), 0);
    chk("R5", "tx_empty cycle after write", int'(tx_empty), 0);
    @(negedge clk);
    chk("R5", "hold_empty after move to shifter", int'(hold_empty), 1);
    chk("R5", "tx_empty while shifting", int'(tx_empty), 0);
    chk("R4", "start bit level", int'(txd), 0);
    wait_flag(1'b0);
    chk("R5", "tx_empty after frame", int'(tx_empty), 1);

    // R12: disable during a character
    fork
      recv_check("R12", 1'b0, 9'h0C3);
      begin
        write_char(8'hC3);
        wait_hold_empty();
        cmd(C_OFF);
        write_char(8'h5A);
      end
    join
    count_low(300, lows);
    chk("R12", "no new frame while off", lows, 0);
    chk("R12", "second char still held", int'(hold_empty), 0);
    cmd(C_ON);
    recv_check("R12", 1'b0, 9'h05A);
    wait_flag(1'b0);

    // R6: reset command mid-frame drops shifted and held characters
    write_char(8'h81);
    repeat (50) @(negedge clk);
    write_char(8'h7E);
    cmd(C_RST);
    @(negedge clk);
    chk("R6", "txd after reset cmd", int'(txd), 1);
    chk("R6", "hold_empty after reset cmd", int'(hold_empty), 1);
    chk("R6", "tx_empty after reset cmd", int'(tx_empty), 1);
    count_low(400, lows);
    chk("R6", "line low after reset cmd", lows, 0);

    // R7 / R8: break waits for the character, second start ignored
    fork
      recv_check("R7", 1'b0, 9'h0F0);
      begin write_char(8'hF0); cmd(C_BS); end
    join
    chk("R7", "brk_active before drain", int'(brk_active), 0);
    chk("R7", "tx_empty with break pending", int'(tx_empty), 0);
    wait_flag(1'b1);
    chk("R7", "brk_active after drain", int'(brk_active), 1);
    chk("R7", "txd during break", int'(txd), 0);
    cmd(C_BS);
    cmd(C_BP);
    wait_flag(1'b0);
    highs = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (brk_active) highs++;
    end
    chk("R8", "break cycles after restart attempt", highs, 0);

    // R9: exact break and gap lengths, both frame sizes
    for (int m = 0; m < 2; m++) begin
      multidrop = m[0];
      cmd(C_BS);
      wait_flag(1'b1);
      lows = 0;
      fork
        cmd(C_BP);
        begin
          while (txd == 1'b0 && lows < 2000) begin lows++; @(negedge clk); end
        end
      join
      chk("R9", "break low cycles", lows, 16 * frame_len(m[0]));
      chk("R9", "brk_active in gap", int'(brk_active), 0);
      highs = 0;
      while (txd == 1'b1 && !tx_empty && highs < 2000) begin highs++; @(negedge clk); end
      chk("R9", "gap high cycles", highs, 12 * 16);
      chk("R9", "idle after gap", int'(tx_empty), 1);
    end
    multidrop = 1'b0;

    // R10: stop before any break is ignored
    cmd(C_BP);
    cmd(C_BS);
    wait_flag(1'b1);
    count_low(400, lows);
    chk("R10", "break held low", lows, 400);
    chk("R10", "brk_active still on", int'(brk_active), 1);
    cmd(C_BP);
    wait_flag(1'b0);
    chk("R10", "break ended after real stop", int'(tx_empty), 1);

    // R11: address mark is one-shot
    multidrop = 1'b1;
    cmd(C_AD);
    fork
      begin
        recv_check("R11", 1'b1, 9'h111);
        recv_check("R11", 1'b1, 9'h022);
      end
      begin
        write_char(8'h11);
        wait_hold_empty();
        write_char(8'h22);
      end
    join
    wait_flag(1'b0);
    multidrop = 1'b0;
    cmd(C_AD);
    fork
      recv_check("R11", 1'b0, 9'h033);
      write_char(8'h33);
    join
    wait_flag(1'b0);
    multidrop = 1'b1;
    fork
      recv_check("R11", 1'b1, 9'h044);
      write_char(8'h44);
    join
    wait_flag(1'b0);

    // R4 / R11: random traffic with sparse ticks
    random_round(1'b0, 12);
    random_round(1'b1, 12);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule